// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

This block serves a grid of push-button contacts wired as rows and columns, where each column has a pull-up. While nothing is pressed, every row output is held low. Closing any contact then pulls its column low, and this wakes the scanner. The scanner lets a fixed settling interval pass so that contact chatter dies out. It then walks the grid and drives one row low at a time. Within each row it tests the columns one per cycle and keeps a code counter that steps on every test. The first low column it meets fixes the key code.

Once a key is identified, all rows go low again and the scanner waits until every column reads high. Only then does it publish the code and raise a single-cycle valid strobe. This means a long hold, chatter, or the column activity caused by the scan itself can never be reported as a second press. The column inputs are asynchronous and pass through a configurable synchroniser. The settling interval and the per-row wait are both counted in clock cycles.

Top module: `keypad_scanner`

## Requirements
- R1: After reset, all row outputs are low, `key_valid_o` is 0 and `key_code_o` is 0.
- R2: While idle, all rows are driven low, and a low level on any column starts a press sequence. The first single-row scan follows within `BOUNCE_CYCLES`+`SYNC_STAGES`+4 cycles of the first contact.
- R3: No row is released from the all-low pattern until at least `BOUNCE_CYCLES` cycles after the first contact closure.
- R4: During a scan, exactly one row line is low. Rows are visited in ascending order, starting at `row_n_o[0]`.
- R5: The reported code is row*COLS + column, where row r is the line `row_n_o[r]` and column c is the line `col_n_i[c]`. With the default size, key k (0 to 15) sits at row k/4, column k%4.
- R6: `key_valid_o` is high for exactly one cycle. It rises only after the key has been released, and never while a contact is still closed.
- R7: Each physical press produces exactly one strobe. This holds even when the closure chatters or the key is held far longer than the scan takes.
- R8: If a complete scan of all rows finds no low column (the key was let go during the settling interval), the block returns to idle with no strobe.
- R9: `key_code_o` changes only in the cycle where `key_valid_o` is high, and holds its value between strobes.
- R10: When several keys are held during a scan, the key with the lowest code is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n_i | input | COLS | Column lines, low when a closed contact joins a low row |
| row_n_o | output | ROWS | Row drive lines, active low |
| key_code_o | output | $clog2(ROWS*COLS) | Code of the last reported key |
| key_valid_o | output | 1 | One-cycle strobe when a new code is published |

## Verification
A corrupted row index or code counter shows up at the strobe as a wrong code. It also shows on the row lines within one row period as an out-of-order or multiple-low row pattern. A state machine stuck in the wait or release phase leaves the rows all low and produces no strobe. The sweep detects this within the hold window of the current press. A settling counter that is too short shows as a scan starting early, which is measured from the first contact closure. A release detector that fires too early produces a strobe while the contact is still modelled as closed, or a second strobe for a single press.

// File: rtl/kps_pkg.sv
package kps_pkg;
   typedef enum logic [2:0] {
      KS_IDLE    = 3'd0,
      KS_BOUNCE  = 3'd1,
      KS_SETTLE  = 3'd2,
      KS_TEST    = 3'd3,
      KS_RELEASE = 3'd4
   } kps_state_t;

   function automatic int unsigned kps_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/kps_sync.sv
module kps_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '1;
               else        stg[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '1;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/kps_timer.sv
module kps_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic         done_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (ld_i)       cnt <= ld_val_i;
      else if (cnt != '0)  cnt <= cnt - W'(1);
   end

   assign done_o = (cnt == '0);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
   parameter int ROWS          = 4,
   parameter int COLS          = 4,
   parameter int SYNC_STAGES   = 2,
   parameter int BOUNCE_CYCLES = 3000000,
   parameter int SETTLE_CYCLES = SYNC_STAGES,
   localparam int CODE_W       = $clog2(ROWS * COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [COLS-1:0]   col_n_i,
   output logic [ROWS-1:0]   row_n_o,
   output logic [CODE_W-1:0] key_code_o,
   output logic              key_valid_o
);
   import kps_pkg::*;

   localparam int RI_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
   localparam int CI_W  = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int TMR_W = $clog2(kps_max(BOUNCE_CYCLES, SETTLE_CYCLES) + 1);
   localparam logic [RI_W-1:0]  ROW_LAST   = RI_W'(ROWS - 1);
   localparam logic [CI_W-1:0]  COL_LAST   = CI_W'(COLS - 1);
   localparam logic [TMR_W-1:0] BOUNCE_LD  = TMR_W'(BOUNCE_CYCLES - 1);
   localparam logic [TMR_W-1:0] SETTLE_LD  = TMR_W'(SETTLE_CYCLES - 1);

   generate
      if (ROWS < 2 || COLS < 2) begin : g_bad_size
         $error("keypad_scanner: ROWS and COLS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("keypad_scanner: SYNC_STAGES must be at least 2");
      end
      if (BOUNCE_CYCLES < 1 || SETTLE_CYCLES < SYNC_STAGES) begin : g_bad_time
         $error("keypad_scanner: settle must cover sync latency, bounce at least 1");
      end
   endgenerate

   logic [COLS-1:0]   col_s;
   logic              tmr_ld;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_done;

   kps_state_t        state;
   logic [RI_W-1:0]   row_idx;
   logic [CI_W-1:0]   col_idx;
   logic [CODE_W-1:0] code_cnt;
   logic [CODE_W-1:0] code_hold;

   kps_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (col_n_i),
      .q_o   (col_s)
   );

   kps_timer #(.W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_i     (tmr_ld),
      .ld_val_i (tmr_val),
      .done_o   (tmr_done)
   );

   // Timer reload requests
   always_comb begin
      tmr_ld  = 1'b0;
      tmr_val = SETTLE_LD;
      unique case (state)
         KS_IDLE: if (!(&col_s)) begin
            tmr_ld  = 1'b1;
            tmr_val = BOUNCE_LD;
         end
         KS_BOUNCE: tmr_ld = tmr_done;
         KS_TEST:   tmr_ld = col_s[col_idx] && (col_idx == COL_LAST) && (row_idx != ROW_LAST);
         default:   tmr_ld = 1'b0;
      endcase
   end

   // Row drive: one row low while scanning, all low otherwise
   always_comb begin
      row_n_o = '0;
      if (state == KS_SETTLE || state == KS_TEST) begin
         row_n_o          = '1;
         row_n_o[row_idx] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= KS_IDLE;
         row_idx     <= '0;
         col_idx     <= '0;
         code_cnt    <= '0;
         code_hold   <= '0;
         key_code_o  <= '0;
         key_valid_o <= 1'b0;
      end else begin
         key_valid_o <= 1'b0;
         unique case (state)
            KS_IDLE: begin
               if (!(&col_s)) state <= KS_BOUNCE;
            end
            KS_BOUNCE: begin
               if (tmr_done) begin
                  row_idx  <= '0;
                  col_idx  <= '0;
                  code_cnt <= '0;
                  state    <= KS_SETTLE;
               end
            end
            KS_SETTLE: begin
               if (tmr_done) state <= KS_TEST;
            end
            KS_TEST: begin
               if (!col_s[col_idx]) begin
                  code_hold <= code_cnt;
                  state     <= KS_RELEASE;
               end else begin
                  code_cnt <= code_cnt + CODE_W'(1);
                  if (col_idx == COL_LAST) begin
                     col_idx <= '0;
                     if (row_idx == ROW_LAST) begin
                        state <= KS_IDLE;
                     end else begin
                        row_idx <= row_idx + RI_W'(1);
                        state   <= KS_SETTLE;
                     end
                  end else begin
                     col_idx <= col_idx + CI_W'(1);
                  end
               end
            end
            KS_RELEASE: begin
               if (&col_s) begin
                  key_code_o  <= code_hold;
                  key_valid_o <= 1'b1;
                  state       <= KS_IDLE;
               end
            end
            default: state <= KS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/keypad_scanner_check.sv
module keypad_scanner_check #(
   parameter int ROWS   = 4,
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ROWS-1:0]   row_n_o,
   input logic [CODE_W-1:0] key_code_o,
   input logic              key_valid_o
);
   // R6: strobe lasts one cycle
   a_r6_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |=> !key_valid_o);

   // R4: either all rows low or exactly one low
   a_r4_row_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      (row_n_o == '0) || ($countones(~row_n_o) == 1));

   // R9: code holds unless a strobe is raised
   a_r9_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !key_valid_o |-> $stable(key_code_o));

   // R2: a strobe is raised only with the matrix back in its idle drive
   a_r2_strobe_rows_idle: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid_o |-> (row_n_o == '0));

   // R4: a single-row scan never jumps straight to a different single row
   a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
      (($countones(~row_n_o) == 1) && ($countones(~$past(row_n_o)) == 1) && !$stable(row_n_o))
      |-> ((~row_n_o) == ((~$past(row_n_o)) << 1)));
endmodule

bind keypad_scanner keypad_scanner_check #(.ROWS(ROWS), .CODE_W(CODE_W)) u_check (
   .clk         (clk),
   .rst_n       (rst_n),
   .row_n_o     (row_n_o),
   .key_code_o  (key_code_o),
   .key_valid_o (key_valid_o)
);

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
   localparam int ROWS   = 4;
   localparam int COLS   = 4;
   localparam int SYNC   = 2;
   localparam int BOUNCE = 40;
   localparam int CODE_W = 4;
   localparam int NKEYS  = ROWS * COLS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [COLS-1:0]   col_n;
   logic [ROWS-1:0]   row_n;
   logic [CODE_W-1:0] key_code;
   logic              key_valid;

   logic [NKEYS-1:0]  pressed = '0;
   logic              contact = 1'b0;

   int errors = 0;
   int checks = 0;

   // monitor state
   int strobe_cnt = 0;
   int last_code  = -1;
   int held_strobe = 0;
   int code_jump  = 0;
   int row_err    = 0;
   int rows_seen  = 0;
   int cur_row    = -1;
   int since_press = 0;
   int first_scan = -1;
   logic [CODE_W-1:0] prev_code = '0;

   always #5 clk = ~clk;

   keypad_scanner #(
      .ROWS(ROWS), .COLS(COLS), .SYNC_STAGES(SYNC), .BOUNCE_CYCLES(BOUNCE)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .col_n_i     (col_n),
      .row_n_o     (row_n),
      .key_code_o  (key_code),
      .key_valid_o (key_valid)
   );

   // switch matrix model with pull-ups
   always_comb begin
      col_n = '1;
      for (int c = 0; c < COLS; c++)
         for (int r = 0; r < ROWS; r++)
            if (!row_n[r] && pressed[r*COLS + c] && contact) col_n[c] = 1'b0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         since_press++;
         if (key_valid) begin
            strobe_cnt++;
            last_code = int'(key_code);
            if (contact && pressed != '0) held_strobe++;
         end else if (key_code != prev_code) begin
            code_jump++;
         end
         prev_code = key_code;
         if (row_n == '0) begin
            cur_row = -1;
         end else if ($countones(~row_n) == 1) begin
            if (first_scan < 0) first_scan = since_press;
            for (int r = 0; r < ROWS; r++) begin
               if (!row_n[r] && r != cur_row) begin
                  if (r != cur_row + 1) row_err++;
                  cur_row = r;
                  rows_seen++;
               end
            end
         end else begin
            row_err++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_mon();
      strobe_cnt = 0; last_code = -1; held_strobe = 0;
      rows_seen = 0; first_scan = -1; since_press = 0;
   endtask

   // press key set, with optional chatter, hold, release cleanly
   task automatic press(input logic [NKEYS-1:0] keys, input bit chatter, input int hold);
      @(negedge clk);
      clear_mon();
      pressed = keys;
      contact = 1'b1;
      if (chatter) begin
         wait_cycles(2); contact = 1'b0;
         wait_cycles(3); contact = 1'b1;
         wait_cycles(2); contact = 1'b0;
         wait_cycles(2); contact = 1'b1;
      end
      wait_cycles(hold);
      contact = 1'b0;
      pressed = '0;
      wait_cycles(20);
   endtask

   initial begin
      int wd = 0;
      while (wd < 150000) begin
         @(posedge clk);
         wd++;
      end
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait_cycles(3);
      // R1: reset state
      check(row_n == '0, "R1 rows", int'(row_n), 0);
      check(key_valid == 1'b0, "R1 valid", int'(key_valid), 0);
      check(key_code == '0, "R1 code", int'(key_code), 0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_cycles(5);

      // R5/R7/R6/R3/R2: sweep every key, alternating chatter
      for (int k = 0; k < NKEYS; k++) begin
         press(NKEYS'(1) << k, (k % 2) == 0, 120);
         check(strobe_cnt == 1, "R7 one strobe per press", strobe_cnt, 1);
         check(last_code == (k / COLS) * COLS + (k % COLS), "R5 key code", last_code, k);
         check(held_strobe == 0, "R6 no strobe while held", held_strobe, 0);
         check(first_scan >= BOUNCE, "R3 settle before scan", first_scan, BOUNCE);
         check(first_scan <= BOUNCE + SYNC + 4, "R2 wake from idle", first_scan, BOUNCE + SYNC + 4);
         check(rows_seen == k / COLS + 1, "R4 rows visited", rows_seen, k / COLS + 1);
      end

      // R7: long hold still gives a single strobe
      press(NKEYS'(1) << 9, 1'b1, 600);
      check(strobe_cnt == 1, "R7 long hold", strobe_cnt, 1);
      check(last_code == 9, "R5 long hold code", last_code, 9);

      // R8: release during settling interval -> full scan, no strobe
      @(negedge clk);
      clear_mon();
      pressed = NKEYS'(1) << 14;
      contact = 1'b1;
      wait_cycles(10);
      contact = 1'b0;
      pressed = '0;
      wait_cycles(120);
      check(strobe_cnt == 0, "R8 no strobe on empty scan", strobe_cnt, 0);
      check(rows_seen == ROWS, "R8 full scan", rows_seen, ROWS);
      check(row_n == '0, "R2 idle rows after empty scan", int'(row_n), 0);
      check(key_code == 4'd9, "R9 code held after empty scan", int'(key_code), 9);

      // R10: two keys held, lowest code wins
      press((NKEYS'(1) << 6) | (NKEYS'(1) << 9), 1'b0, 120);
      check(last_code == 6, "R10 lowest code 6/9", last_code, 6);
      press((NKEYS'(1) << 13) | (NKEYS'(1) << 3), 1'b1, 120);
      check(last_code == 3, "R10 lowest code 3/13", last_code, 3);
      check(strobe_cnt == 1, "R7 multi-key single strobe", strobe_cnt, 1);

      // R9 and R4 over the whole run
      check(code_jump == 0, "R9 code stable between strobes", code_jump, 0);
      check(row_err == 0, "R4 row order and pattern", row_err, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule